// File: doc/BRIEF.md
# Power-Down Exit Termination Phase Tracker

This block sits in a DDR3 memory controller and owns the clock-enable pin on the way out of precharge power-down. When the mode-register DLL-control setting says the DLL stays frozen during power-down, the memory answers ODT changes asynchronously while powered down, synchronously once its DLL has relocked, and either way in a transition window around the exit. The block schedules the CKE rise so that this window opens a fixed lookahead before CKE goes high. It raises one of three phase flags (asynchronous, uncertain, synchronous) and reports every ODT pin edge together with its phase and the earliest and latest absolute cycle at which termination may change.

Latencies come in as mode-register fields, given in clock cycles. The asynchronous and synchronous turn-on and turn-off bounds are design parameters in cycles. Window bounds are absolute values of a free-running cycle counter. Edge reports leave on a valid/ready stream. A report stays on the port, unchanged, until the consumer accepts it. An edge that arrives while an unaccepted report is held is dropped. When a report is accepted in the same cycle as a new edge, the new report takes its place without a gap. Control and flag pins are plain levels.

Top module: `pdx_odt_tracker`

## Requirements
- R1: During and after reset, before any request, `cke` is 0, only `ph_async` is set and `ev_valid` is 0. In every cycle exactly one phase flag is set.
- R2: With `mr_dll_ctl` = 0, an accepted exit request (`exit_req` sampled while powered down) sets `ph_uncertain` from the next cycle. `cke` rises exactly tANPD = AL + CWL - 1 cycles after `ph_uncertain` rises, which gives 9 cycles for AL = 5 and CWL = 5.
- R3: `ph_uncertain` clears exactly `txpdll_cyc` cycles after `cke` rises. In that same cycle `ph_sync` sets.
- R4: With `mr_dll_ctl` = 1, an accepted exit request raises `cke` and `ph_sync` in the next cycle, and `ph_uncertain` never sets.
- R5: `exit_req` and `pd_req` have no effect while an exit is in progress, meaning while `ph_uncertain` is set.
- R6: `pd_req` sampled in the synchronous phase drops `cke` and returns the flags to `ph_async` in the next cycle.
- R7: Each clock edge at which `odt_in` differs from its value at the previous edge produces one report. The report is visible after that edge. `ev_rise` is the new pin value, `ev_stamp` is the cycle counter value just before the edge (the counter starts at 0 in reset and increments every cycle), and `ev_phase` encodes the flags just before the edge: 0 = asynchronous, 1 = synchronous, 2 = uncertain.
- R8: An asynchronous edge has early/late = stamp + AONPD_MIN/AONPD_MAX for a rise and stamp + AOFPD_MIN/AOFPD_MAX for a fall.
- R9: A synchronous edge has early/late = stamp + (WL - 2) + AON_MIN/AON_MAX for a rise and stamp + (WL - 2) + AOF_MIN/AOF_MAX for a fall, with WL = AL + CWL.
- R10: An uncertain edge has early = the smaller of the asynchronous and synchronous lower bounds and late = the larger of the two upper bounds.
- R11: While `ev_valid` is set and `ev_ready` is low, every report field stays unchanged and edges are dropped. An accept with a simultaneous edge loads the new report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mr_dll_ctl | input | 1 | Mode-register DLL control: 0 = DLL frozen in power-down |
| al_cyc | input | 5 | Additive latency in cycles |
| cwl_cyc | input | 5 | CAS write latency in cycles |
| txpdll_cyc | input | 8 | DLL relock time after CKE high, cycles (at least 1) |
| exit_req | input | 1 | Request to leave power-down |
| pd_req | input | 1 | Request to enter power-down |
| odt_in | input | 1 | Current ODT pin value |
| cke | output | 1 | Clock enable toward the memory |
| ph_async | output | 1 | Asynchronous ODT response phase |
| ph_uncertain | output | 1 | Transition window phase |
| ph_sync | output | 1 | Synchronous ODT response phase |
| ev_valid | output | 1 | Edge report valid |
| ev_ready | input | 1 | Consumer accepts the report |
| ev_rise | output | 1 | 1 = ODT asserted, 0 = de-asserted |
| ev_phase | output | 2 | Phase code of the edge |
| ev_stamp | output | 24 | Cycle of the edge |
| ev_early | output | 24 | Earliest cycle of the termination change |
| ev_late | output | 24 | Latest cycle of the termination change |

## Verification
An ODT edge and a phase change can fall in the same cycle: at the window opening, at the CKE rise, at the window close and at power-down entry. The bench toggles `odt_in` on every cycle of every exit sequence, so every phase boundary has an edge landing on it. Each report's phase and bounds are judged against the flags the bench predicts for the cycle just before the edge. A new edge also arrives in the same cycle as a stream accept, and the bench verifies that the new report replaces the old one without a gap.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
  typedef enum logic [1:0] {
    PH_ASYNC  = 2'd0,
    PH_SYNC   = 2'd1,
    PH_UNCERT = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    S_PD   = 2'd0,
    S_PRE  = 2'd1,
    S_EXIT = 2'd2,
    S_SYNC = 2'd3
  } seq_e;
endpackage

// File: rtl/pdx_cycle_ctr.sv
module pdx_cycle_ctr #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cyc
);
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1'b1;
  end
endmodule

// File: rtl/pdx_exit_seq.sv
module pdx_exit_seq
  import pdx_pkg::*;
#(
  parameter int LW = 5,
  parameter int XW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mr_dll_ctl,
  input  logic [LW-1:0] al_cyc,
  input  logic [LW-1:0] cwl_cyc,
  input  logic [XW-1:0] txpdll_cyc,
  input  logic          exit_req,
  input  logic          pd_req,
  output logic          cke,
  output phase_e        phase
);
  localparam int KW = (LW + 1 > XW) ? LW + 1 : XW;

  seq_e          st;
  logic [KW-1:0] cnt;
  logic [LW:0]   tanpd;

  assign tanpd = {1'b0, al_cyc} + {1'b0, cwl_cyc} - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_PD;
      cnt <= '0;
    end else begin
      case (st)
        S_PD: if (exit_req) begin
          if (!mr_dll_ctl) begin
            st  <= S_PRE;
            cnt <= KW'(tanpd) - 1'b1;
          end else begin
            st <= S_SYNC;
          end
        end
        S_PRE: if (cnt == '0) begin
          st  <= S_EXIT;
          cnt <= KW'(txpdll_cyc) - 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_EXIT: if (cnt == '0) st <= S_SYNC;
                else           cnt <= cnt - 1'b1;
        default: if (pd_req) st <= S_PD;
      endcase
    end
  end

  assign cke = (st == S_EXIT) || (st == S_SYNC);

  always_comb begin
    case (st)
      S_PRE, S_EXIT: phase = PH_UNCERT;
      S_SYNC:        phase = PH_SYNC;
      default:       phase = PH_ASYNC;
    endcase
  end

  logic unc;
  assign unc = (phase == PH_UNCERT);

  assert_cke_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> ($past(phase) == PH_UNCERT) || $past(mr_dll_ctl));
  assert_window_closes_to_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unc) |-> (phase == PH_SYNC) && cke);
  assert_window_opens_cke_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unc) |-> !cke);
  assert_pd_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SYNC) && pd_req |=> !cke && (phase == PH_ASYNC));
  assert_no_pd_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unc && pd_req |=> phase != PH_ASYNC);
endmodule

// File: rtl/pdx_odt_window.sv
module pdx_odt_window
  import pdx_pkg::*;
#(
  parameter int CW        = 24,
  parameter int LW        = 5,
  parameter int AONPD_MIN = 2,
  parameter int AONPD_MAX = 9,
  parameter int AOFPD_MIN = 2,
  parameter int AOFPD_MAX = 9,
  parameter int AON_MIN   = 0,
  parameter int AON_MAX   = 1,
  parameter int AOF_MIN   = 0,
  parameter int AOF_MAX   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          odt_in,
  input  phase_e        phase,
  input  logic [LW-1:0] al_cyc,
  input  logic [LW-1:0] cwl_cyc,
  input  logic [CW-1:0] cyc,
  output logic          hit,
  output logic          rise,
  output phase_e        ph,
  output logic [CW-1:0] stamp,
  output logic [CW-1:0] early,
  output logic [CW-1:0] late
);
  logic          odt_q;
  logic [CW-1:0] odtl;
  logic [CW-1:0] a_lo, a_hi, s_lo, s_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) odt_q <= 1'b0;
    else        odt_q <= odt_in;
  end

  assign hit   = (odt_in != odt_q);
  assign rise  = odt_in;
  assign ph    = phase;
  assign stamp = cyc;
  assign odtl  = CW'(al_cyc) + CW'(cwl_cyc) - CW'(2);

  always_comb begin
    if (odt_in) begin
      a_lo = cyc + CW'(AONPD_MIN);
      a_hi = cyc + CW'(AONPD_MAX);
      s_lo = cyc + odtl + CW'(AON_MIN);
      s_hi = cyc + odtl + CW'(AON_MAX);
    end else begin
      a_lo = cyc + CW'(AOFPD_MIN);
      a_hi = cyc + CW'(AOFPD_MAX);
      s_lo = cyc + odtl + CW'(AOF_MIN);
      s_hi = cyc + odtl + CW'(AOF_MAX);
    end
    case (phase)
      PH_SYNC: begin
        early = s_lo;
        late  = s_hi;
      end
      PH_UNCERT: begin
        early = (a_lo < s_lo) ? a_lo : s_lo;
        late  = (a_hi > s_hi) ? a_hi : s_hi;
      end
      default: begin
        early = a_lo;
        late  = a_hi;
      end
    endcase
  end
endmodule

// File: rtl/pdx_event_port.sv
module pdx_event_port
  import pdx_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          in_rise,
  input  phase_e        in_ph,
  input  logic [CW-1:0] in_stamp,
  input  logic [CW-1:0] in_early,
  input  logic [CW-1:0] in_late,
  output logic          ev_valid,
  input  logic          ev_ready,
  output logic          ev_rise,
  output logic [1:0]    ev_phase,
  output logic [CW-1:0] ev_stamp,
  output logic [CW-1:0] ev_early,
  output logic [CW-1:0] ev_late
);
  logic free;
  assign free = !ev_valid || ev_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_rise  <= 1'b0;
      ev_phase <= 2'd0;
      ev_stamp <= '0;
      ev_early <= '0;
      ev_late  <= '0;
    end else if (free) begin
      ev_valid <= hit;
      if (hit) begin
        ev_rise  <= in_rise;
        ev_phase <= in_ph;
        ev_stamp <= in_stamp;
        ev_early <= in_early;
        ev_late  <= in_late;
      end
    end
  end

  assert_hold_under_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_stamp) && $stable(ev_early)
                              && $stable(ev_late) && $stable(ev_rise) && $stable(ev_phase));
  assert_bounds_ordered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_early <= ev_late);
  assert_phase_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_phase != 2'd3);
endmodule

// File: rtl/pdx_odt_tracker.sv
module pdx_odt_tracker
  import pdx_pkg::*;
#(
  parameter int CW        = 24,
  parameter int LW        = 5,
  parameter int XW        = 8,
  parameter int AONPD_MIN = 2,
  parameter int AONPD_MAX = 9,
  parameter int AOFPD_MIN = 2,
  parameter int AOFPD_MAX = 9,
  parameter int AON_MIN   = 0,
  parameter int AON_MAX   = 1,
  parameter int AOF_MIN   = 0,
  parameter int AOF_MAX   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mr_dll_ctl,
  input  logic [LW-1:0] al_cyc,
  input  logic [LW-1:0] cwl_cyc,
  input  logic [XW-1:0] txpdll_cyc,
  input  logic          exit_req,
  input  logic          pd_req,
  input  logic          odt_in,
  output logic          cke,
  output logic          ph_async,
  output logic          ph_uncertain,
  output logic          ph_sync,
  output logic          ev_valid,
  input  logic          ev_ready,
  output logic          ev_rise,
  output logic [1:0]    ev_phase,
  output logic [CW-1:0] ev_stamp,
  output logic [CW-1:0] ev_early,
  output logic [CW-1:0] ev_late
);
  phase_e        phase, w_ph;
  logic [CW-1:0] cyc, w_stamp, w_early, w_late;
  logic          w_hit, w_rise;

  pdx_cycle_ctr #(.CW(CW)) u_ctr (.clk(clk), .rst_n(rst_n), .cyc(cyc));

  pdx_exit_seq #(.LW(LW), .XW(XW)) u_seq (
    .clk(clk), .rst_n(rst_n), .mr_dll_ctl(mr_dll_ctl), .al_cyc(al_cyc),
    .cwl_cyc(cwl_cyc), .txpdll_cyc(txpdll_cyc), .exit_req(exit_req),
    .pd_req(pd_req), .cke(cke), .phase(phase));

  pdx_odt_window #(
    .CW(CW), .LW(LW), .AONPD_MIN(AONPD_MIN), .AONPD_MAX(AONPD_MAX),
    .AOFPD_MIN(AOFPD_MIN), .AOFPD_MAX(AOFPD_MAX), .AON_MIN(AON_MIN),
    .AON_MAX(AON_MAX), .AOF_MIN(AOF_MIN), .AOF_MAX(AOF_MAX)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .odt_in(odt_in), .phase(phase), .al_cyc(al_cyc),
    .cwl_cyc(cwl_cyc), .cyc(cyc), .hit(w_hit), .rise(w_rise), .ph(w_ph),
    .stamp(w_stamp), .early(w_early), .late(w_late));

  pdx_event_port #(.CW(CW)) u_port (
    .clk(clk), .rst_n(rst_n), .hit(w_hit), .in_rise(w_rise), .in_ph(w_ph),
    .in_stamp(w_stamp), .in_early(w_early), .in_late(w_late),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_rise(ev_rise),
    .ev_phase(ev_phase), .ev_stamp(ev_stamp), .ev_early(ev_early),
    .ev_late(ev_late));

  assign ph_async     = (phase == PH_ASYNC);
  assign ph_uncertain = (phase == PH_UNCERT);
  assign ph_sync      = (phase == PH_SYNC);

  assert_flags_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ph_async, ph_uncertain, ph_sync}));
  assert_sync_needs_cke_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ph_sync |-> cke);
  assert_report_stamp_past_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_valid) |-> ev_stamp == $past(cyc));
endmodule

// File: tb/pdx_odt_tracker_test.sv
module pdx_odt_tracker_test;
  localparam int CW = 24;
  localparam int AONPD_MIN = 2, AONPD_MAX = 9, AOFPD_MIN = 3, AOFPD_MAX = 8;
  localparam int AON_MIN = 0, AON_MAX = 1, AOF_MIN = 1, AOF_MAX = 2;
  localparam int BIG = 1000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mr_dll_ctl = 1'b0, exit_req = 1'b0, pd_req = 1'b0, odt_in = 1'b0, ev_ready = 1'b1;
  logic [4:0] al_cyc = 5'd5, cwl_cyc = 5'd5;
  logic [7:0] txpdll_cyc = 8'd4;
  logic cke, ph_async, ph_uncertain, ph_sync, ev_valid, ev_rise;
  logic [1:0] ev_phase;
  logic [CW-1:0] ev_stamp, ev_early, ev_late;

  int compared = 0, mismatched = 0;
  int n, E, P, ta, tx, wl;
  bit dll_on;

  always #4 clk = ~clk;

  pdx_odt_tracker #(
    .CW(CW), .AONPD_MIN(AONPD_MIN), .AONPD_MAX(AONPD_MAX), .AOFPD_MIN(AOFPD_MIN),
    .AOFPD_MAX(AOFPD_MAX), .AON_MIN(AON_MIN), .AON_MAX(AON_MAX),
    .AOF_MIN(AOF_MIN), .AOF_MAX(AOF_MAX)
  ) uut (.*);

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at n=%0d: actual %0d expected %0d", req, n, act, exp);
    end
  endtask

  function automatic int exp_ph(int k);
    if (k >= P || k < E) return 0;
    if (dll_on) return 1;
    return (k < E + ta + tx) ? 2 : 1;
  endfunction

  function automatic int exp_cke(int k);
    if (k >= P || k < E) return 0;
    if (dll_on) return 1;
    return (k >= E + ta) ? 1 : 0;
  endfunction

  task automatic step();
    @(negedge clk);
    n++;
  endtask

  task automatic chk_flags(string req);
    int ph = exp_ph(n);
    chk(req, int'(cke), exp_cke(n));
    chk(req, int'(ph_async), int'(ph == 0));
    chk(req, int'(ph_uncertain), int'(ph == 2));
    chk(req, int'(ph_sync), int'(ph == 1));
  endtask

  task automatic chk_event(int t, bit r, string req);
    int ph = exp_ph(t);
    int alo = t + (r ? AONPD_MIN : AOFPD_MIN);
    int ahi = t + (r ? AONPD_MAX : AOFPD_MAX);
    int slo = t + wl - 2 + (r ? AON_MIN : AOF_MIN);
    int shi = t + wl - 2 + (r ? AON_MAX : AOF_MAX);
    int elo = (ph == 0) ? alo : (ph == 1) ? slo : ((alo < slo) ? alo : slo);
    int ehi = (ph == 0) ? ahi : (ph == 1) ? shi : ((ahi > shi) ? ahi : shi);
    chk({req, " R7 valid"}, int'(ev_valid), 1);
    chk({req, " R7 rise"}, int'(ev_rise), int'(r));
    chk({req, " R7 stamp"}, int'(ev_stamp), t);
    chk({req, " R7 phase"}, int'(ev_phase), ph);
    chk({req, " R8/R9/R10 early"}, int'(ev_early), elo);
    chk({req, " R8/R9/R10 late"}, int'(ev_late), ehi);
  endtask

  task automatic run_cfg(int al, int cwl, int txv, bit dll);
    int last, q;
    bit prev_r;
    string tag;
    al_cyc = 5'(al); cwl_cyc = 5'(cwl); txpdll_cyc = 8'(txv); mr_dll_ctl = dll;
    ta = al + cwl - 1; tx = txv; wl = al + cwl; dll_on = dll;
    E = BIG; P = BIG;
    rst_n = 1'b0; odt_in = 1'b0; ev_ready = 1'b1; exit_req = 1'b0; pd_req = 1'b0;
    repeat (3) @(negedge clk);
    n = 0;
    // R1: reset state
    chk("R1 cke", int'(cke), 0);
    chk("R1 async", int'(ph_async), 1);
    chk("R1 unc", int'(ph_uncertain), 0);
    chk("R1 sync", int'(ph_sync), 0);
    chk("R1 valid", int'(ev_valid), 0);
    rst_n = 1'b1;
    E = 5;
    q = dll ? 9 : E + ta + tx + 3;
    P = q + 1;
    last = P + 3;
    tag = dll ? "R4" : "R2/R3";
    prev_r = 1'b0;
    while (n < last) begin
      step();
      chk_flags(n < P ? tag : "R6");
      if (!dll && n >= 6 && n < E + ta + tx) chk_flags("R5");
      if (n >= 2) chk_event(n - 1, prev_r, "stream");
      // drive for the next edge
      exit_req = (n == 4) || (!dll && n == 6);
      pd_req   = (!dll && n == 7) || (n == q);
      odt_in   = (n >= 1) ? ~odt_in : odt_in;
      prev_r   = odt_in;
    end
    exit_req = 1'b0; pd_req = 1'b0;
    if (!dll) begin
      chk("R2 tANPD", ta, al + cwl - 1);
      if (al == 5 && cwl == 5) chk("R2 tANPD=9", ta, 9);
    end
    // R11: back-pressure: no toggle, drain
    step();
    step();
    chk("R11 drained", int'(ev_valid), 0);
    ev_ready = 1'b0; odt_in = ~odt_in; prev_r = odt_in;
    step();
    chk_event(n - 1, prev_r, "R11 load");
    odt_in = ~odt_in;
    step();
    chk_event(n - 2, prev_r, "R11 hold");
    ev_ready = 1'b1;
    step();
    chk("R11 drop", int'(ev_valid), 0);
  endtask

  bit done = 1'b0;
  initial begin
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 3; a++)
        for (int c = 0; c < 3; c++)
          for (int x = 0; x < 3; x++)
            run_cfg((a == 0) ? 0 : (a == 1) ? 5 : 7,
                    (c == 0) ? 5 : (c == 1) ? 6 : 8,
                    (x == 0) ? 1 : (x == 1) ? 4 : 10, bit'(d));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule